// File: doc/BRIEF.md
# Hot-Swap Insertion, Fault and Restart Sequencer

This block decides when the enable of an external series pass switch may be driven, on a hot-plug supply path. A single tick counter stands in for the analog timing capacitor. It times three phases in turn. The first is a settling delay after power-up. The second is a fault timeout that runs only while the analog current or power limit loop reports that it is regulating. The third is a long restart delay used in auto-retry mode.

Input voltage qualification arrives as two comparator levels. The sequencer treats the input as valid only when it is above the undervoltage point and not above the overvoltage point. A host can switch the path off and back on with two command strobes. That off-then-on pair is also the only way to clear a latched fault. The power-good output is the switch enable qualified by the input window.

The restart delay is a parameterised multiple of the fault timeout, 200 by default. In retry mode the switch therefore stays on for roughly half a percent of each cycle while a fault persists.

Top module: `hotswap_seq`

## Requirements
- R1: After reset is released, `gate_en_o` stays 0 for exactly INSERT_TICKS ticks, whatever the window, limit and command inputs do. Commands are ignored during this time.
- R2: At the end of the insertion delay, `gate_en_o` goes to 1 on the next cycle if the window is valid (`uv_ok_i`=1 and `ov_i`=0). Otherwise the sequencer waits, and it turns the gate on one cycle after the window becomes valid.
- R3: Whenever the window is invalid at a clock edge while the sequencer is waiting, on, timing a fault or restarting, the gate is off from that edge on. The sequencer then returns to waiting for the window.
- R4: While on, each tick with `limit_i`=1 advances the fault timer, and `limiting_o` is 1 while the timer runs. One tick with `limit_i`=0 resets the timer and leaves the gate on. FAULT_TICKS consecutive limiting ticks turn the gate off and set `fault_o`.
- R5: With `retry_i`=1 sampled at the timeout, the gate stays off for RESTART_TICKS = FAULT_TICKS*RESTART_RATIO ticks and then turns on again. This repeats while limiting persists.
- R6: With `retry_i`=0 at the timeout, the gate stays off through any window activity until the off/on command pair arrives.
- R7: Outside the insertion delay, `cmd_off_i` turns the gate off at the next edge, and it wins over `cmd_on_i` in the same cycle. `cmd_on_i` after an off clears `fault_o` and resumes through the wait-for-window step. `cmd_on_i` without a prior off has no effect.
- R8: `pgood_en_o` is 1 only while the gate is enabled and the window is valid. It drops in the same cycle the window becomes invalid.
- R9: During reset all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uv_ok_i | input | 1 | Input is above the undervoltage threshold |
| ov_i | input | 1 | Input is above the overvoltage threshold |
| limit_i | input | 1 | Current or power limit loop is regulating |
| retry_i | input | 1 | 1 selects auto-retry, 0 selects latch-off |
| cmd_on_i | input | 1 | Host on command strobe |
| cmd_off_i | input | 1 | Host off command strobe |
| gate_en_o | output | 1 | Pass switch enable |
| limiting_o | output | 1 | Fault timer running under limit |
| fault_o | output | 1 | Fault timeout latched |
| pgood_en_o | output | 1 | Power-good gate |

## Verification
A wrong phase or a wrong timer count shows up on `gate_en_o` as an edge at the wrong cycle. It appears one tick early or late at the end of insertion, at the fault timeout or at the end of a restart. A latched fault that is wrongly held or wrongly cleared shows on `fault_o` at the command edge. A mis-handled window loss shows in the same cycle on `pgood_en_o` and one edge later on `gate_en_o`. The bench runs a behavioural model in step with the design and compares every output on every clock. A divergence is therefore reported in the cycle it first reaches a port.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    ST_INSERT,
    ST_WAIT,
    ST_ON,
    ST_FTIME,
    ST_RESTART,
    ST_LATCH,
    ST_HOSTOFF
  } hs_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/hs_tick_gen.sv
module hs_tick_gen #(
  parameter int TICK_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/hs_phase_timer.sv
module hs_phase_timer #(
  parameter int CNT_W   = 8,
  parameter int MAX_CNT = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_CNT);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end
  assign cnt_o = cnt_q;

  // shared timer never runs past the longest phase (R5 restart is the longest)
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_TOP);
endmodule

// File: rtl/hs_window.sv
module hs_window (
  input  logic uv_ok_i,
  input  logic ov_i,
  input  logic gate_on_i,
  output logic win_o,
  output logic pgood_o
);
  assign win_o   = uv_ok_i & ~ov_i;
  assign pgood_o = gate_on_i & win_o;
endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq #(
  parameter int INSERT_TICKS  = 20,
  parameter int FAULT_TICKS   = 10,   // minimum 2
  parameter int RESTART_RATIO = 200,
  parameter int TICK_DIV      = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_ok_i,
  input  logic ov_i,
  input  logic limit_i,
  input  logic retry_i,
  input  logic cmd_on_i,
  input  logic cmd_off_i,
  output logic gate_en_o,
  output logic limiting_o,
  output logic fault_o,
  output logic pgood_en_o
);
  import hs_pkg::*;

  localparam int RESTART_TICKS = FAULT_TICKS * RESTART_RATIO;
  localparam int MAX_TICKS     = max3(INSERT_TICKS, FAULT_TICKS, RESTART_TICKS);
  localparam int CNT_W         = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] INS_LAST = CNT_W'(INSERT_TICKS - 1);
  localparam logic [CNT_W-1:0] FLT_LAST = CNT_W'(FAULT_TICKS - 1);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RESTART_TICKS - 1);

  hs_state_e        st_q, st_d;
  logic             fault_q, fault_d;
  logic             tick, win, gate_on;
  logic             t_clr, t_inc;
  logic [CNT_W-1:0] cnt;

  hs_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  hs_phase_timer #(.CNT_W(CNT_W), .MAX_CNT(MAX_TICKS)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (t_clr),
    .inc_i (t_inc),
    .cnt_o (cnt)
  );

  hs_window i_win (
    .uv_ok_i  (uv_ok_i),
    .ov_i     (ov_i),
    .gate_on_i(gate_on),
    .win_o    (win),
    .pgood_o  (pgood_en_o)
  );

  always_comb begin
    st_d    = st_q;
    fault_d = fault_q;
    t_clr   = 1'b0;
    t_inc   = 1'b0;
    if (st_q == ST_INSERT) begin
      // insertion runs to completion; nothing interrupts it
      t_inc = tick;
      if (tick && cnt == INS_LAST) begin
        t_clr = 1'b1;
        st_d  = win ? ST_ON : ST_WAIT;
      end
    end else if (cmd_off_i) begin
      t_clr = 1'b1;
      st_d  = ST_HOSTOFF;
    end else begin
      unique case (st_q)
        ST_HOSTOFF: begin
          t_clr = 1'b1;
          if (cmd_on_i) begin
            fault_d = 1'b0;
            st_d    = ST_WAIT;
          end
        end
        ST_WAIT: begin
          t_clr = 1'b1;
          if (win) st_d = ST_ON;
        end
        ST_ON: begin
          if (!win) begin
            t_clr = 1'b1;
            st_d  = ST_WAIT;
          end else if (limit_i) begin
            t_inc = tick;
            st_d  = ST_FTIME;
          end else begin
            t_clr = 1'b1;
          end
        end
        ST_FTIME: begin
          if (!win) begin
            t_clr = 1'b1;
            st_d  = ST_WAIT;
          end else if (!limit_i) begin
            t_clr = 1'b1;
            st_d  = ST_ON;
          end else begin
            t_inc = tick;
            if (tick && cnt == FLT_LAST) begin
              t_clr   = 1'b1;
              fault_d = 1'b1;
              st_d    = retry_i ? ST_RESTART : ST_LATCH;
            end
          end
        end
        ST_RESTART: begin
          if (!win) begin
            t_clr = 1'b1;
            st_d  = ST_WAIT;
          end else begin
            t_inc = tick;
            if (tick && cnt == RST_LAST) begin
              t_clr = 1'b1;
              st_d  = ST_ON;
            end
          end
        end
        ST_LATCH: t_clr = 1'b1;
        default: begin
          t_clr = 1'b1;
          st_d  = ST_WAIT;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_INSERT;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_q <= fault_d;
    end
  end

  assign gate_on    = (st_q == ST_ON) || (st_q == ST_FTIME);
  assign gate_en_o  = gate_on;
  assign limiting_o = (st_q == ST_FTIME);
  assign fault_o    = fault_q;

  p_gate_needs_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_o |-> $past(win));

  p_fault_rise_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(limit_i));

  p_latch_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LATCH) && !cmd_off_i |=> (st_q == ST_LATCH));

  p_fault_clear_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> $past(cmd_on_i));
endmodule

// File: tb/test_hotswap_seq.sv
module test_hotswap_seq;
  localparam int INS = 20;
  localparam int FLT = 10;
  localparam int RAT = 200;
  localparam int RST = FLT * RAT;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic uv_ok_i = 1'b1, ov_i = 1'b0, limit_i = 1'b0, retry_i = 1'b1;
  logic cmd_on_i = 1'b0, cmd_off_i = 1'b0;
  logic gate_en_o, limiting_o, fault_o, pgood_en_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  hotswap_seq #(.INSERT_TICKS(INS), .FAULT_TICKS(FLT), .RESTART_RATIO(RAT), .TICK_DIV(1)) i_hotswap_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .uv_ok_i(uv_ok_i), .ov_i(ov_i), .limit_i(limit_i),
    .retry_i(retry_i), .cmd_on_i(cmd_on_i), .cmd_off_i(cmd_off_i), .gate_en_o(gate_en_o),
    .limiting_o(limiting_o), .fault_o(fault_o), .pgood_en_o(pgood_en_o));

  // reference model: phase names and remaining-ticks style
  string m_phase = "insert";
  int    m_left  = INS;
  int    m_run   = 0;
  bit    m_fault = 1'b0;

  always @(posedge clk_i) begin
    bit w;
    w = uv_ok_i && !ov_i;
    if (!rst_ni) begin
      m_phase = "insert"; m_left = INS; m_run = 0; m_fault = 1'b0;
    end else if (m_phase == "insert") begin
      m_left--;
      if (m_left == 0) m_phase = w ? "on" : "wait";
    end else if (cmd_off_i) begin
      m_phase = "off";
    end else if (m_phase == "off") begin
      if (cmd_on_i) begin m_phase = "wait"; m_fault = 1'b0; end
    end else if (m_phase == "wait") begin
      if (w) m_phase = "on";
    end else if (m_phase == "on") begin
      if (!w) m_phase = "wait";
      else if (limit_i) begin m_phase = "limit"; m_run = 1; end
    end else if (m_phase == "limit") begin
      if (!w) m_phase = "wait";
      else if (!limit_i) m_phase = "on";
      else begin
        m_run++;
        if (m_run == FLT) begin
          m_fault = 1'b1;
          if (retry_i) begin m_phase = "restart"; m_left = RST; end
          else m_phase = "latched";
        end
      end
    end else if (m_phase == "restart") begin
      if (!w) m_phase = "wait";
      else begin
        m_left--;
        if (m_left == 0) m_phase = "on";
      end
    end
  end

  function automatic string tag_of(string ph);
    if (ph == "insert")  return "R1";
    if (ph == "limit")   return "R4";
    if (ph == "restart") return "R5";
    if (ph == "latched") return "R6";
    if (ph == "off")     return "R7";
    return "R3";
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    bit g, w;
    #1;
    if (!done) begin
      w = uv_ok_i && !ov_i;
      g = (m_phase == "on") || (m_phase == "limit");
      chk(gate_en_o, g, tag_of(m_phase), "gate_en");
      chk(limiting_o, m_phase == "limit", "R4", "limiting");
      chk(fault_o, m_fault, "R7", "fault");
      chk(pgood_en_o, g && w, "R8", "pgood");
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #3;
    end
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    chk(gate_en_o, 1'b0, "R9", "reset gate");
    chk(fault_o, 1'b0, "R9", "reset fault");
    chk(limiting_o, 1'b0, "R9", "reset limiting");
    chk(pgood_en_o, 1'b0, "R9", "reset pgood");
    rst_ni = 1'b1;
    step(5);
    cmd_off_i = 1'b1;
    step(1);
    cmd_off_i = 1'b0;
    step(13);
    chk(gate_en_o, 1'b0, "R1", "gate during last insert tick");
    step(1);
    chk(gate_en_o, 1'b1, "R2", "gate after insertion");
    // short limiting burst
    limit_i = 1'b1;
    step(2);
    chk(limiting_o, 1'b1, "R4", "timer running");
    step(FLT - 4);
    limit_i = 1'b0;
    step(2);
    chk(gate_en_o, 1'b1, "R4", "gate kept after short limit");
    chk(fault_o, 1'b0, "R4", "no fault after short limit");
    // window loss
    ov_i = 1'b1;
    #1;
    chk(pgood_en_o, 1'b0, "R8", "pgood drops with window");
    step(1);
    chk(gate_en_o, 1'b0, "R3", "gate off on window loss");
    ov_i = 1'b0;
    step(1);
    chk(gate_en_o, 1'b1, "R3", "gate back with window");
    // retry mode
    retry_i = 1'b1;
    limit_i = 1'b1;
    step(FLT - 1);
    chk(gate_en_o, 1'b1, "R4", "gate before timeout");
    step(1);
    chk(gate_en_o, 1'b0, "R4", "gate off at timeout");
    chk(fault_o, 1'b1, "R4", "fault set at timeout");
    step(RST - 1);
    chk(gate_en_o, 1'b0, "R5", "gate off through restart");
    step(1);
    chk(gate_en_o, 1'b1, "R5", "gate on after restart");
    step(FLT);
    chk(gate_en_o, 1'b0, "R5", "second timeout");
    limit_i = 1'b0;
    step(RST);
    chk(gate_en_o, 1'b1, "R5", "recovered after restart");
    chk(fault_o, 1'b1, "R5", "fault still latched");
    // commands
    cmd_on_i = 1'b1;
    step(1);
    cmd_on_i = 1'b0;
    chk(fault_o, 1'b1, "R7", "lone on ignored");
    cmd_off_i = 1'b1;
    cmd_on_i = 1'b1;
    step(1);
    cmd_on_i = 1'b0;
    cmd_off_i = 1'b0;
    chk(gate_en_o, 1'b0, "R7", "off wins over on");
    chk(fault_o, 1'b1, "R7", "fault kept on off+on");
    step(3);
    cmd_on_i = 1'b1;
    step(1);
    cmd_on_i = 1'b0;
    chk(fault_o, 1'b0, "R7", "fault cleared by on");
    step(1);
    chk(gate_en_o, 1'b1, "R7", "gate back after on");
    // latch-off mode
    retry_i = 1'b0;
    limit_i = 1'b1;
    step(FLT);
    limit_i = 1'b0;
    chk(gate_en_o, 1'b0, "R6", "latched off");
    uv_ok_i = 1'b0;
    step(3);
    uv_ok_i = 1'b1;
    step(5);
    chk(gate_en_o, 1'b0, "R6", "stays off after window cycle");
    chk(fault_o, 1'b1, "R6", "fault held");
    cmd_off_i = 1'b1;
    step(1);
    cmd_off_i = 1'b0;
    cmd_on_i = 1'b1;
    step(1);
    cmd_on_i = 1'b0;
    step(1);
    chk(gate_en_o, 1'b1, "R6", "released by off/on");
    // insertion ending outside window
    rst_ni = 1'b0;
    uv_ok_i = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(INS + 5);
    chk(gate_en_o, 1'b0, "R2", "waits for window");
    uv_ok_i = 1'b1;
    step(1);
    chk(gate_en_o, 1'b1, "R2", "on when window arrives");
    chk(pgood_en_o, 1'b1, "R8", "pgood with gate and window");
    step(2);
    finish_run();
  end
endmodule